// File: doc/BRIEF.md
# Group Clock Divider with Parked Stop

This block turns a fast internal clock into one divided output clock for a group of clock outputs. A 4-bit ratio code chooses the divide ratio. A table-select input chooses between two ratio sets: one for the processor and 66 MHz groups, and one for the bus group. Odd ratios are built from rising edges only. Every output period starts with its low phase. The ratio register updates only at the end of a period, so changing the code never shortens a pulse.

The output is either one single-ended clock or a true/complement pair. An inversion input flips the polarity of the running clock. An output enable and a stop request can each park the output. Parking waits until the output is already at its park level, so no pulse is cut short. In single-ended mode the park level is low. In differential mode the true leg parks high and the complement leg parks low. The stop request is sampled by two clock edges before it acts. The enable is already synchronous, so it is used directly. When the output is released it starts a fresh period from the beginning of the low phase, using the current code.

Top module: `grp_clk_divider`

## Requirements
- R1: With table_sel=0, ratio_code[1:0] of 00/01/10/11 selects a base of 2/3/5/7. ratio_code[3:2] of 00/01/10/11 multiplies the base by 1/2/4/8, so N runs from 2 to 56.
- R2: With table_sel=1, the bases are 4/3/5/9 with the same scaling by ratio_code[3:2], so N runs from 3 to 72.
- R3: Each output period is N input cycles. It is low for floor(N/2) cycles first, then high for ceil(N/2) cycles.
- R4: A new ratio code takes effect only at the end of the current output period. The pulse in progress keeps its old length.
- R5: invert=1 inverts the running output polarity, so the high and low lengths swap.
- R6: In single-ended mode (diff_mode=0), clk_c is held low. When out_en goes low or a stop is requested, the current high pulse completes in full, and clk_t then stays low.
- R7: stop_req passes through two sampling flops before it is acted on. Out_en acts on the next edge.
- R8: In differential mode (diff_mode=1), clk_c is the inverse of clk_t while running. A parked pair holds clk_t=1 and clk_c=0.
- R9: After release from park, the output restarts at the first cycle of a fresh period, in the low phase, with the current code.
- R10: A synchronous active-low reset drives clk_t and clk_c low and loads the ratio from the current code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_code | input | 4 | Ratio code: [1:0] base, [3:2] power-of-two scale |
| table_sel | input | 1 | 0: processor/66 MHz ratio set, 1: bus ratio set |
| invert | input | 1 | Polarity inversion of the running output |
| out_en | input | 1 | Output enable; low parks the output |
| stop_req | input | 1 | Stop request, sampled by two edges, parks the output |
| diff_mode | input | 1 | 0: single-ended, 1: true/complement pair |
| clk_t | output | 1 | Divided clock (true leg) |
| clk_c | output | 1 | Complement leg; low in single-ended mode |

## Verification
A wrong ratio register or a wrong phase counter shows up at clk_t within one output period. It appears as a high or low run length that differs from ceil(N/2) or floor(N/2), or as a truncated pulse right after a code change. A wrong park state shows up within one period of a stop or disable: clk_t fails to settle at the park level, or clk_c breaks away from its complement or low value. The restart delay after release is checked to the exact cycle. An error in the two-flop stop sampler therefore appears as a first rising edge that is early or late by one or more samples.

// File: rtl/rcg_pkg.sv
// Shared widths and types for the group clock divider.
// Assumes a 4-bit ratio code: two base bits and two scale bits.
package rcg_pkg;
    localparam int CODE_W  = 4;
    localparam int SCALE_W = CODE_W - 2;
    localparam int BASE_W  = 4;
    // Largest ratio is a 4-bit base shifted by the largest scale.
    localparam int NDIV_W  = BASE_W + (1 << SCALE_W) - 1;

    typedef enum logic {
        TBL_CORE = 1'b0,
        TBL_BUS  = 1'b1
    } tbl_e;
endpackage

// File: rtl/rcg_ratio_decode.sv
// Combinational ratio decoder: base factor from the low code bits,
// power-of-two scale from the high code bits.
// Assumes the ratio table is chosen by tbl, and that the result is never below 2.
module rcg_ratio_decode
    import rcg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  tbl_e              tbl,
    output logic [NDIV_W-1:0] ratio
);
    logic [BASE_W-1:0] base;

    // Pick the base factor from the selected table, then apply the scale.
    always_comb begin
        unique case (code[1:0])
            2'd0:    base = (tbl == TBL_BUS) ? BASE_W'(4) : BASE_W'(2);
            2'd1:    base = BASE_W'(3);
            2'd2:    base = BASE_W'(5);
            default: base = (tbl == TBL_BUS) ? BASE_W'(9) : BASE_W'(7);
        endcase
        ratio = NDIV_W'(base) << code[CODE_W-1:2];
    end
endmodule

// File: rtl/rcg_stop_sync.sv
// Samples the stop request through STAGES flops before it reaches the
// park logic.
// Assumes STAGES >= 1.
module rcg_stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single sampling flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d;
            end
        end else begin : g_chain
            // Shift chain of sampling flops.
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rcg_phase_gen.sv
// Period counter, park state and registered output pair.
// Each period is a low phase of floor(N/2) cycles followed by a high phase
// of ceil(N/2) cycles. The ratio is reloaded at a period end or while parked.
// Parking waits until the visible level equals the park level.
// Assumes ratio_new >= 2.
module rcg_phase_gen
    import rcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NDIV_W-1:0] ratio_new,
    input  logic              invert,
    input  logic              park_rq,
    input  logic              diff_mode,
    output logic              clk_t,
    output logic              clk_c,
    output logic              run_q,
    output logic [NDIV_W-1:0] cnt_q,
    output logic [NDIV_W-1:0] n_act_q
);
    logic [NDIV_W-1:0] lo_len;
    logic              base_lvl;
    logic              vis;
    logic              park_lvl;
    logic              at_park;
    logic              period_end;

    // Derive phase level, park level and period end from the counter.
    always_comb begin
        lo_len     = n_act_q >> 1;
        base_lvl   = (cnt_q >= lo_len);
        vis        = base_lvl ^ invert;
        park_lvl   = diff_mode;
        at_park    = (vis == park_lvl);
        period_end = (cnt_q == n_act_q - NDIV_W'(1));
    end

    // Advance the counter, reload the ratio and track the park state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            n_act_q <= ratio_new;
            run_q   <= 1'b1;
        end else if (run_q) begin
            if (park_rq && at_park) begin
                run_q   <= 1'b0;
                cnt_q   <= '0;
                n_act_q <= ratio_new;
            end else if (period_end) begin
                cnt_q   <= '0;
                n_act_q <= ratio_new;
            end else begin
                cnt_q   <= cnt_q + NDIV_W'(1);
            end
        end else begin
            cnt_q   <= '0;
            n_act_q <= ratio_new;
            if (!park_rq) run_q <= 1'b1;
        end
    end

    // Register the output pair: running level or park level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_t <= 1'b0;
            clk_c <= 1'b0;
        end else if (run_q) begin
            clk_t <= vis;
            clk_c <= diff_mode & ~vis;
        end else begin
            clk_t <= park_lvl;
            clk_c <= 1'b0;
        end
    end
endmodule

// File: rtl/grp_clk_divider.sv
// Top of the group clock divider: ratio decode, stop sampling and phase
// generation.
// Assumes all inputs are synchronous to clk except stop_req, which is
// sampled through SYNC_STAGES flops.
module grp_clk_divider
    import rcg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              table_sel,
    input  logic              invert,
    input  logic              out_en,
    input  logic              stop_req,
    input  logic              diff_mode,
    output logic              clk_t,
    output logic              clk_c
);
    logic [NDIV_W-1:0] ratio_w;
    logic              stop_s;
    logic              park_rq;
    logic              run_w;
    logic [NDIV_W-1:0] cnt_w;
    logic [NDIV_W-1:0] n_act_w;

    rcg_ratio_decode u_dec (
        .code  (ratio_code),
        .tbl   (tbl_e'(table_sel)),
        .ratio (ratio_w)
    );

    rcg_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stop_req),
        .q     (stop_s)
    );

    // Combine the direct enable with the sampled stop request.
    always_comb park_rq = ~out_en | stop_s;

    rcg_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_new (ratio_w),
        .invert    (invert),
        .park_rq   (park_rq),
        .diff_mode (diff_mode),
        .clk_t     (clk_t),
        .clk_c     (clk_c),
        .run_q     (run_w),
        .cnt_q     (cnt_w),
        .n_act_q   (n_act_w)
    );
endmodule

// File: rtl/rcg_checker.sv
// Property checker for the group clock divider, bound to the top module.
// Assumes the synchronous active-low reset of the top.
module rcg_checker
    import rcg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              diff_mode,
    input logic              clk_t,
    input logic              clk_c,
    input logic              run_q,
    input logic [NDIV_W-1:0] cnt_q,
    input logic [NDIV_W-1:0] n_act_q
);
    // R3: a running counter stays inside the active period.
    a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < n_act_q));

    // R4: the ratio register holds except at a period end.
    a_r4_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_q) && run_q &&
         ($past(cnt_q) != $past(n_act_q) - NDIV_W'(1))) |-> $stable(n_act_q));

    // R6: the complement leg stays low in single-ended mode.
    a_r6_se_comp_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(diff_mode)) |-> !clk_c);

    // R6: a parked single-ended output is low.
    a_r6_se_park_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_q) && !$past(diff_mode)) |-> !clk_t);

    // R8: a running differential pair is complementary.
    a_r8_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_q) && $past(diff_mode)) |-> (clk_c == !clk_t));

    // R8: a parked differential pair holds true high and complement low.
    a_r8_pair_parked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_q) && $past(diff_mode)) |-> (clk_t && !clk_c));

    // R9: leaving park starts a fresh period.
    a_r9_fresh_period: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(run_q)) |-> (cnt_q == '0));
endmodule

bind grp_clk_divider rcg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .diff_mode (diff_mode),
    .clk_t     (clk_t),
    .clk_c     (clk_c),
    .run_q     (run_w),
    .cnt_q     (cnt_w),
    .n_act_q   (n_act_w)
);

// File: tb/grp_clk_divider_tb.sv
// Self-checking bench: a vector table of ratio codes, then directed tests.
module grp_clk_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ratio_code = 4'b0100;
    logic       table_sel = 1'b0;
    logic       invert = 1'b0;
    logic       out_en = 1'b1;
    logic       stop_req = 1'b0;
    logic       diff_mode = 1'b0;
    logic       clk_t;
    logic       clk_c;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    grp_clk_divider u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .table_sel  (table_sel),
        .invert     (invert),
        .out_en     (out_en),
        .stop_req   (stop_req),
        .diff_mode  (diff_mode),
        .clk_t      (clk_t),
        .clk_c      (clk_c)
    );

    // {table_sel, code, high length, low length}
    typedef logic [18:0] vec_t;
    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        {1'b0, 4'b0000, 7'd1,  7'd1},
        {1'b0, 4'b0001, 7'd2,  7'd1},
        {1'b0, 4'b0010, 7'd3,  7'd2},
        {1'b0, 4'b0011, 7'd4,  7'd3},
        {1'b0, 4'b0100, 7'd2,  7'd2},
        {1'b0, 4'b1011, 7'd14, 7'd14},
        {1'b0, 4'b1111, 7'd28, 7'd28},
        {1'b0, 4'b1101, 7'd12, 7'd12},
        {1'b1, 4'b0000, 7'd2,  7'd2},
        {1'b1, 4'b0011, 7'd5,  7'd4},
        {1'b1, 4'b1001, 7'd6,  7'd6},
        {1'b1, 4'b1111, 7'd36, 7'd36},
        {1'b1, 4'b0110, 7'd5,  7'd5},
        {1'b1, 4'b1011, 7'd18, 7'd18}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count samples until clk_t equals v, including the matching sample.
    task automatic wait_for(input logic v, input int lim, output int n);
        n = 0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            n++;
            if (clk_t === v) return;
        end
    endtask

    // Length of a run of v starting at the current sample (assumed v).
    task automatic run_len(input logic v, input int lim, output int n);
        n = 1;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (clk_t === v) n++;
            else return;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int   hi;
        int   lo;
        int   n;
        int   mis;
        vec_t v;

        // R10: outputs low during reset, even in differential mode.
        diff_mode  = 1'b1;
        ratio_code = 4'b0100;
        rst_n      = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 clk_t in reset", int'(clk_t), 0);
        check("R10 clk_c in reset", int'(clk_c), 0);
        rst_n = 1'b1;

        // R8: running pair is complementary.
        mis = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (clk_c !== ~clk_t) mis++;
        end
        check("R8 complement mismatches", mis, 0);

        // R8: parked pair holds true high, complement low.
        stop_req = 1'b1;
        repeat (20) @(negedge clk);
        mis = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!(clk_t === 1'b1 && clk_c === 1'b0)) mis++;
        end
        check("R8 parked pair mismatches", mis, 0);
        stop_req  = 1'b0;
        diff_mode = 1'b0;

        // R1 R2 R3: ratio table walk.
        for (int i = 0; i < NVEC; i++) begin
            v          = VECS[i];
            table_sel  = v[18];
            ratio_code = v[17:14];
            do_reset();
            wait_for(1'b1, 200, n);
            run_len(1'b1, 200, hi);
            run_len(1'b0, 200, lo);
            check(v[18] ? "R2 high length" : "R1 high length", hi, int'(v[13:7]));
            check("R3 low length", lo, int'(v[6:0]));
        end

        // R4: code change mid-pulse keeps old pulse, new ratio next period.
        table_sel  = 1'b0;
        ratio_code = 4'b0110;
        do_reset();
        wait_for(1'b1, 200, n);
        ratio_code = 4'b0000;
        run_len(1'b1, 200, hi);
        check("R4 old high kept", hi, 5);
        run_len(1'b0, 200, lo);
        check("R4 new low", lo, 1);
        run_len(1'b1, 200, hi);
        check("R4 new high", hi, 1);

        // R5: inversion swaps high and low lengths for N=3.
        ratio_code = 4'b0001;
        invert     = 1'b1;
        do_reset();
        wait_for(1'b1, 200, n);
        run_len(1'b1, 200, hi);
        run_len(1'b0, 200, lo);
        check("R5 inverted high", hi, 1);
        check("R5 inverted low", lo, 2);
        invert = 1'b0;

        // R6: stop completes the high pulse and then holds low.
        ratio_code = 4'b0110;
        do_reset();
        wait_for(1'b1, 200, n);
        stop_req = 1'b1;
        run_len(1'b1, 200, hi);
        check("R6 stop keeps full high", hi, 5);
        run_len(1'b0, 59, lo);
        check("R6 stopped low run", lo, 60);
        check("R6 clk_c low single-ended", int'(clk_c), 0);

        // R7 R9: release after two sampling edges, fresh period from low.
        stop_req = 1'b0;
        wait_for(1'b1, 200, n);
        check("R7 first high after stop release", n, 9);
        run_len(1'b1, 200, hi);
        check("R9 high after restart", hi, 5);

        // R6: disable also completes the pulse and parks low.
        do_reset();
        wait_for(1'b1, 200, n);
        out_en = 1'b0;
        run_len(1'b1, 200, hi);
        check("R6 disable keeps full high", hi, 5);
        run_len(1'b0, 39, lo);
        check("R6 disabled low run", lo, 40);

        // R9: enable restarts without the sampling delay.
        out_en = 1'b1;
        wait_for(1'b1, 200, n);
        check("R9 first high after enable", n, 7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule